// File: doc/BRIEF.md
# Carry-Skip Adder with Zero-Carry Stages and Inverting Skip Chain

This block adds two unsigned operands and a carry-in and returns the sum together with a carry-out. It is purely combinational. The operand width is split into slices. Each slice is summed by a ripple chain that always starts from a carry of zero, so every slice computes its partial sum, its local carry and its all-propagate flag at the same time. A per-slice incrementer then adds the carry that actually arrives at the slice boundary.

The carries between slices travel through compound inverting gates rather than multiplexers. A slice whose incoming carry is true uses an AND-OR-Invert function and passes on the complemented carry. The next slice takes that complemented carry into an OR-AND-Invert function and restores the true polarity. The final carry-out is corrected if the last slice leaves it complemented.

The slice width is a parameter and does not have to divide the operand width. The top slice takes whatever bits remain.

Top module: `cska_ci_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the 33-bit value a + b + cin, where a and b are unsigned and cin is 0 or 1.
- R2: Adding 2159 and 9542 gives a sum of 11701 when cin is 0 and 11702 when cin is 1, with cout 0 in both cases.
- R3: 0xFFFFFFFF + 0 with cin 1 gives sum 0 and cout 1: the carry passes through every slice.
- R4: Raising cin from 0 to 1 with a and b unchanged increases the 33-bit result {cout, sum} by exactly one.
- R5: When a XOR b is all ones, cout equals cin. The sum is then 0 if cin is 1 and 0xFFFFFFFF if cin is 0.
- R6: A carry generated inside one slice reaches the next slice. For example, 0x0000000F + 0x00000001 with cin 0 gives 0x00000010 with 4-bit slices.
- R7: The result of R1 holds for a slice width that does not divide the operand width, for example 5-bit slices over 32 bits with a 2-bit top slice.
- R8: All-zero inputs give sum 0 and cout 0. All-ones operands with cin 1 give sum 0xFFFFFFFF and cout 1.
- R9: Within every slice, the true carry leaving the slice equals the incoming carry whenever the slice's operand bits all propagate, and it is 1 whenever the zero-carry ripple of the slice produces a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH (32) | First addend |
| b | input | WIDTH (32) | Second addend |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH (32) | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
In a single evaluation a slice can both skip the arriving carry and overflow its own partial sum in the incrementer. That happens when every operand bit of the slice propagates and the incoming carry is 1: the partial sum is all ones, and the increment wraps it to zero while the skip gate forwards the carry. The bench provokes this with operand pairs whose XOR is all ones, whole-word and per-slice, combined with cin of 1. It runs them on two instances, one with 4-bit slices and one with 5-bit slices. It judges each result against an integer reference sum on every clock. It also checks that the incremented slices read zero while cout equals cin.

// File: rtl/cska_pkg.sv
package cska_pkg;
   // number of slices needed to cover a word of width w with slices of width s
   function automatic int slice_count(input int w, input int s);
      return (w + s - 1) / s;
   endfunction

   // width of slice idx; the top slice takes the remainder
   function automatic int slice_width(input int w, input int s, input int idx);
      int lo;
      lo = idx * s;
      return ((lo + s) > w) ? (w - lo) : s;
   endfunction

   // a slice whose index is even emits a complemented carry
   function automatic bit emits_inverted(input int idx);
      return (idx % 2) == 0;
   endfunction
endpackage

// File: rtl/cska_zero_rca.sv
module cska_zero_rca #(
   parameter int W = 4
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] part_sum,
   output logic         loc_gen,
   output logic         loc_prop
);
   logic [W:0]   rc;
   logic [W-1:0] hx;

   assign rc[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_fa
      assign hx[i]       = op_a[i] ^ op_b[i];
      assign part_sum[i] = hx[i] ^ rc[i];
      assign rc[i+1]     = (op_a[i] & op_b[i]) | (hx[i] & rc[i]);
   end

   assign loc_gen  = rc[W];
   assign loc_prop = &hx;

   // R9: generate and propagate of one slice never hold together
   always_comb begin
      if (!$isunknown({op_a, op_b}))
         a_r9_gen_prop_exclusive: assert (!(loc_gen && loc_prop));
   end
endmodule

// File: rtl/cska_incr.sv
module cska_incr #(
   parameter int W = 4
) (
   input  logic [W-1:0] part_sum,
   input  logic         c_in,
   output logic [W-1:0] fin_sum
);
   logic [W-1:0] k;

   assign k[0] = c_in;

   for (genvar i = 0; i < W; i++) begin : g_ha
      assign fin_sum[i] = part_sum[i] ^ k[i];
      if (i < W - 1) begin : g_next
         assign k[i+1] = part_sum[i] & k[i];
      end
   end
endmodule

// File: rtl/cska_slice.sv
module cska_slice #(
   parameter int W      = 4,
   parameter bit IN_INV = 1'b0   // incoming carry arrives complemented
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         c_pol_in,
   output logic [W-1:0] s_out,
   output logic         c_pol_out
);
   logic [W-1:0] psum;
   logic         gen, prop, c_true_in, c_true_out;

   cska_zero_rca #(.W(W)) u_rca (
      .op_a     (op_a),
      .op_b     (op_b),
      .part_sum (psum),
      .loc_gen  (gen),
      .loc_prop (prop)
   );

   assign c_true_in = IN_INV ? ~c_pol_in : c_pol_in;

   cska_incr #(.W(W)) u_inc (
      .part_sum (psum),
      .c_in     (c_true_in),
      .fin_sum  (s_out)
   );

   if (IN_INV) begin : g_oai
      // inputs complemented: restore true carry with OR-AND-Invert
      logic ng, np;
      assign ng         = ~gen;
      assign np         = ~prop;
      assign c_pol_out  = ~(ng & (np | c_pol_in));
      assign c_true_out = c_pol_out;
   end else begin : g_aoi
      // true carry in: AND-OR-Invert emits complemented carry
      assign c_pol_out  = ~(gen | (prop & c_pol_in));
      assign c_true_out = ~c_pol_out;
   end

   always_comb begin
      if (!$isunknown({op_a, op_b, c_pol_in})) begin
         // R1: slice result matches its own arithmetic sum
         a_r1_slice_sum: assert ({c_true_out, s_out} ==
            ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_true_in}));
         // R9: full propagation hands the carry straight through
         if (prop) a_r9_skip_pass: assert (c_true_out == c_true_in);
         // R9: a local carry always leaves the slice
         if (gen) a_r9_gen_leaves: assert (c_true_out);
      end
   end
endmodule

// File: rtl/cska_ci_adder.sv
module cska_ci_adder #(
   parameter int WIDTH   = 32,
   parameter int STAGE_W = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   import cska_pkg::*;

   localparam int NSTG = slice_count(WIDTH, STAGE_W);
   localparam bit LAST_INV = emits_inverted(NSTG - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("cska_ci_adder: WIDTH must be at least 2");
   end
   if (STAGE_W < 1 || STAGE_W > WIDTH) begin : g_bad_stage
      $error("cska_ci_adder: STAGE_W must lie in 1..WIDTH");
   end

   logic [NSTG:0] chain;

   assign chain[0] = cin;

   for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
      localparam int LO = gi * STAGE_W;
      localparam int SW = slice_width(WIDTH, STAGE_W, gi);

      cska_slice #(
         .W      (SW),
         .IN_INV (!emits_inverted(gi))
      ) u_slice (
         .op_a      (a[LO +: SW]),
         .op_b      (b[LO +: SW]),
         .c_pol_in  (chain[gi]),
         .s_out     (sum[LO +: SW]),
         .c_pol_out (chain[gi+1])
      );
   end

   if (LAST_INV) begin : g_fix_out
      assign cout = ~chain[NSTG];
   end else begin : g_pass_out
      assign cout = chain[NSTG];
   end

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         // R1: whole-word result equals the unsigned sum
         a_r1_word_sum: assert ({cout, sum} ==
            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
         // R5: all-propagate word passes cin to cout
         if (&(a ^ b)) a_r5_word_skip: assert (cout == cin);
      end
   end
endmodule

// File: tb/cska_ci_adder_tb.sv
`timescale 1ns/1ps
module cska_ci_adder_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] a = '0, b = '0;
   logic        cin = 1'b0;
   logic [31:0] sum, sum5;
   logic        cout, cout5;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   cska_ci_adder #(.WIDTH(32), .STAGE_W(4)) u_dut (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

   cska_ci_adder #(.WIDTH(32), .STAGE_W(5)) u_dut5 (
      .a(a), .b(b), .cin(cin), .sum(sum5), .cout(cout5));

   function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                           input logic c);
      longint unsigned t;
      t = longint'(x) + longint'(y) + longint'(c);
      return t[32:0];
   endfunction

   task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive on the falling edge, judge after the next rising edge
   task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c,
                        input string tag);
      @(negedge clk);
      a = x; b = y; cin = c;
      @(posedge clk);
      #1;
      chk({tag, " [4-bit slices]"}, {cout, sum}, ref_add(x, y, c));
      chk({"R7 ", tag, " [5-bit slices]"}, {cout5, sum5}, ref_add(x, y, c));
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [32:0] r0, r1;
      repeat (2) @(posedge clk);
      #1;
      chk("R8 zero state", {cout, sum}, 33'd0);

      apply(32'd2159, 32'd9542, 1'b0, "R2 cin0");
      chk("R2 literal 11701", {cout, sum}, 33'd11701);
      apply(32'd2159, 32'd9542, 1'b1, "R2 cin1");
      chk("R2 literal 11702", {cout, sum}, 33'd11702);

      apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R3 full ripple");
      chk("R3 literal", {cout, sum}, {1'b1, 32'h0});

      apply(32'h0000_000F, 32'h1, 1'b0, "R6 boundary carry");
      chk("R6 literal", {cout, sum}, 33'h0_0000_0010);
      apply(32'h0000_001F, 32'h1, 1'b0, "R6 boundary carry 5b");
      chk("R7 R6 5-bit literal", {cout5, sum5}, 33'h0_0000_0020);

      apply(32'h0, 32'h0, 1'b0, "R8 zeros");
      chk("R8 zeros literal", {cout, sum}, 33'd0);
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 ones");
      chk("R8 ones literal", {cout, sum}, {1'b1, 32'hFFFF_FFFF});

      // skip and incrementer overflow in the same evaluation
      for (int k = 0; k < 8; k++) begin
         logic [31:0] x;
         x = $urandom();
         apply(x, ~x, 1'b1, "R5 propagate cin1");
         chk("R5 cout follows cin=1", {cout, sum}, {1'b1, 32'h0});
         apply(x, ~x, 1'b0, "R5 propagate cin0");
         chk("R5 cout follows cin=0", {cout, sum}, {1'b0, 32'hFFFF_FFFF});
      end

      // one slice fully propagating while neighbours generate
      apply(32'h0000_0A5F, 32'h0000_05A1, 1'b0, "R1 mixed slices");
      apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R1 top slice");
      apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 top carry");

      for (int k = 0; k < 20; k++) begin
         logic [31:0] x, y;
         x = $urandom(); y = $urandom();
         apply(x, y, 1'b0, "R4 base");
         r0 = {cout, sum};
         apply(x, y, 1'b1, "R4 plus");
         r1 = {cout, sum};
         chk("R4 cin adds one", r1, r0 + 33'd1);
      end

      for (int k = 0; k < 300; k++) begin
         apply($urandom(), $urandom(), 1'($urandom()), "R1 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule